// File: doc/BRIEF.md
# DTMF Keypad Key Decode and Tone Control

This block sits between a four-by-four telephone keypad and a dual-tone generator. It samples four active-low row lines and four active-low column lines without edge detection, using level sampling. It counts how many rows and how many columns are closed, and from that it decides which tone groups the generator should produce. It returns the row index that selects the low-group frequency and the column index that selects the high-group frequency. It also drives a mute flag for the line interface and a run enable for the tone oscillator.

Two control pins shape the decision. A single-tone permit input lets a press with several rows and one column, or one row and several columns, produce the one tone that is still unambiguous. A tone-allow input, when low, silences both groups and stops the oscillator, but it does not change the mute flag. All eight key lines and both control pins pass through a two-flop synchronizer. One output register follows the synchronizer.

Top module: `dtmf_key_ctrl`

## Requirements
- R1: With tone-allow high, exactly one active row and exactly one active column set both low_en_o and high_en_o.
- R2: With single-tone permit high and tone-allow high, two or more active rows with exactly one active column set high_en_o only, and col_idx_o gives that column.
- R3: With single-tone permit high and tone-allow high, exactly one active row with two or more active columns set low_en_o only, and row_idx_o gives that row.
- R4: Two or more active rows together with two or more active columns clear both enables.
- R5: With single-tone permit low, every key pattern except exactly one row with one column clears both enables.
- R6: mute_o is 1 whenever at least one row or column line is low, whatever the single-tone permit and tone-allow levels are, and 0 otherwise.
- R7: With tone-allow low, low_en_o, high_en_o and run_o are 0 for any key pattern.
- R8: With no row or column active, low_en_o, high_en_o, run_o and mute_o are all 0.
- R9: run_o is 1 only while at least one tone enable is 1. Column lines active without a row give run_o = 0.
- R10: A change on any input shows at the outputs on the third rising clock edge after it is applied, and not before.
- R11: row_idx_o and col_idx_o encode the first to fourth row or column as 0 to 3, in bit order 0 to 3 of row_ni and col_ni. row_idx_o holds its last value while low_en_o is 0, and col_idx_o holds its last value while high_en_o is 0.
- R12: While rst_ni is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_ni | input | 4 | Row lines, active low; bit 0 is the first row |
| col_ni | input | 4 | Column lines, active low; bit 0 is the first column |
| single_ok_i | input | 1 | Single-tone permit; 1 allows single-group output |
| tone_allow_i | input | 1 | 0 silences both tone groups and the oscillator |
| low_en_o | output | 1 | Low-group (row) tone enable |
| high_en_o | output | 1 | High-group (column) tone enable |
| row_idx_o | output | 2 | Selected row, 0 to 3 |
| col_idx_o | output | 2 | Selected column, 0 to 3 |
| mute_o | output | 1 | 1 while any key line is active |
| run_o | output | 1 | Oscillator run enable |

## Verification
All results are due together on the third rising edge after a stimulus: two edges in the synchronizer and one in the output register. The bench drives inputs on the falling edge. It waits three rising edges and samples shortly after the last one, so each check reads a settled registered value. In the latency test the bench samples after the second edge and confirms that the outputs still show the old state, then samples after the third edge and confirms the new state. Index-hold checks carry the expected indices forward from the last scenario that enabled each group.

// File: rtl/dtmf_key_pkg.sv
package dtmf_key_pkg;
  typedef enum logic [1:0] {
    CNT_NONE  = 2'd0,
    CNT_ONE   = 2'd1,
    CNT_MULTI = 2'd2
  } key_cnt_e;
endpackage

// File: rtl/dtmf_key_sync.sv
module dtmf_key_sync #(
  parameter int unsigned         W      = 10,
  parameter int unsigned         STAGES = 2,
  parameter logic [W-1:0]        RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= RST_VAL;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dtmf_key_class.sv
module dtmf_key_class
  import dtmf_key_pkg::*;
#(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     act_i,
  output key_cnt_e         cnt_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int unsigned CNT_W = $clog2(N + 1);

  logic [CNT_W-1:0] n;

  always_comb begin
    n     = '0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (act_i[i]) begin
        n     = n + CNT_W'(1);
        idx_o = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (n == '0)              cnt_o = CNT_NONE;
    else if (n == CNT_W'(1))  cnt_o = CNT_ONE;
    else                      cnt_o = CNT_MULTI;
  end
endmodule

// File: rtl/dtmf_key_ctrl.sv
module dtmf_key_ctrl
  import dtmf_key_pkg::*;
#(
  parameter int unsigned N_ROWS      = 4,
  parameter int unsigned N_COLS      = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ROW_W = (N_ROWS > 1) ? $clog2(N_ROWS) : 1,
  localparam int unsigned COL_W = (N_COLS > 1) ? $clog2(N_COLS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_ROWS-1:0] row_ni,
  input  logic [N_COLS-1:0] col_ni,
  input  logic              single_ok_i,
  input  logic              tone_allow_i,
  output logic              low_en_o,
  output logic              high_en_o,
  output logic [ROW_W-1:0]  row_idx_o,
  output logic [COL_W-1:0]  col_idx_o,
  output logic              mute_o,
  output logic              run_o
);
  localparam int unsigned SW = N_ROWS + N_COLS + 2;
  localparam logic [SW-1:0] SYNC_IDLE = {1'b1, 1'b0, {N_COLS{1'b1}}, {N_ROWS{1'b1}}};

  // synchronized vector: {allow, single_ok, col_n, row_n}
  logic [SW-1:0] key_s;

  dtmf_key_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_IDLE)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({tone_allow_i, single_ok_i, col_ni, row_ni}),
    .q_o    (key_s)
  );

  logic [N_ROWS-1:0] row_act;
  logic [N_COLS-1:0] col_act;
  logic              single_ok_s, allow_s;

  assign row_act     = ~key_s[N_ROWS-1:0];
  assign col_act     = ~key_s[N_ROWS +: N_COLS];
  assign single_ok_s = key_s[SW-2];
  assign allow_s     = key_s[SW-1];

  key_cnt_e          row_cnt, col_cnt;
  logic [ROW_W-1:0]  row_idx;
  logic [COL_W-1:0]  col_idx;

  dtmf_key_class #(.N(N_ROWS), .IDX_W(ROW_W)) i_row_class (
    .act_i (row_act),
    .cnt_o (row_cnt),
    .idx_o (row_idx)
  );

  dtmf_key_class #(.N(N_COLS), .IDX_W(COL_W)) i_col_class (
    .act_i (col_act),
    .cnt_o (col_cnt),
    .idx_o (col_idx)
  );

  logic low_d, high_d, valid_pair;

  always_comb begin
    valid_pair = (row_cnt == CNT_ONE) && (col_cnt == CNT_ONE);
    low_d  = 1'b0;
    high_d = 1'b0;
    if (allow_s) begin
      if (valid_pair) begin
        low_d  = 1'b1;
        high_d = 1'b1;
      end else if (single_ok_s) begin
        high_d = (row_cnt == CNT_MULTI) && (col_cnt == CNT_ONE);
        low_d  = (row_cnt == CNT_ONE)   && (col_cnt == CNT_MULTI);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_en_o  <= 1'b0;
      high_en_o <= 1'b0;
      row_idx_o <= '0;
      col_idx_o <= '0;
      mute_o    <= 1'b0;
      run_o     <= 1'b0;
    end else begin
      low_en_o  <= low_d;
      high_en_o <= high_d;
      run_o     <= low_d | high_d;
      mute_o    <= (|row_act) | (|col_act);
      if (low_d)  row_idx_o <= row_idx;
      if (high_d) col_idx_o <= col_idx;
    end
  end
endmodule

// File: rtl/dtmf_key_chk.sv
module dtmf_key_chk #(
  parameter int unsigned N_ROWS = 4,
  parameter int unsigned N_COLS = 4,
  localparam int unsigned ROW_W = (N_ROWS > 1) ? $clog2(N_ROWS) : 1,
  localparam int unsigned COL_W = (N_COLS > 1) ? $clog2(N_COLS) : 1,
  localparam int unsigned SW = N_ROWS + N_COLS + 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SW-1:0]    key_s_i,
  input logic             low_en_i,
  input logic             high_en_i,
  input logic [ROW_W-1:0] row_idx_i,
  input logic [COL_W-1:0] col_idx_i,
  input logic             mute_i,
  input logic             run_i
);
  logic [N_ROWS-1:0] r_act;
  logic [N_COLS-1:0] c_act;
  logic              ok_s, allow_s;

  assign r_act   = ~key_s_i[N_ROWS-1:0];
  assign c_act   = ~key_s_i[N_ROWS +: N_COLS];
  assign ok_s    = key_s_i[SW-2];
  assign allow_s = key_s_i[SW-1];

  a_r1_pair_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (allow_s && $countones(r_act) == 1 && $countones(c_act) == 1) |=> (low_en_i && high_en_i));

  a_r4_multi_multi_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(r_act) > 1 && $countones(c_act) > 1) |=> (!low_en_i && !high_en_i));

  a_r5_no_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ok_s && !($countones(r_act) == 1 && $countones(c_act) == 1)) |=> (!low_en_i && !high_en_i));

  a_r6_mute_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|r_act) || (|c_act)) |=> mute_i);

  a_r7_disable_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !allow_s |=> (!low_en_i && !high_en_i && !run_i));

  a_r9_run_needs_tone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (low_en_i || high_en_i));

  a_r11_row_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !low_en_i |-> $stable(row_idx_i));

  a_r11_col_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !high_en_i |-> $stable(col_idx_i));
endmodule

bind dtmf_key_ctrl dtmf_key_chk #(.N_ROWS(N_ROWS), .N_COLS(N_COLS)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .key_s_i   (key_s),
  .low_en_i  (low_en_o),
  .high_en_i (high_en_o),
  .row_idx_i (row_idx_o),
  .col_idx_i (col_idx_o),
  .mute_i    (mute_o),
  .run_i     (run_o)
);

// File: tb/test_dtmf_key_ctrl.sv
`timescale 1ns/1ps
module test_dtmf_key_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] row_n = 4'hF, col_n = 4'hF;
  logic       single_ok = 1'b0, allow = 1'b1;
  logic       low_en, high_en, mute, run;
  logic [1:0] row_idx, col_idx;
  int         checks = 0, failures = 0;
  logic [1:0] exp_r = 2'd0, exp_c = 2'd0;

  always #10 clk = ~clk;

  dtmf_key_ctrl i_dtmf_key_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .row_ni(row_n), .col_ni(col_n),
    .single_ok_i(single_ok), .tone_allow_i(allow),
    .low_en_o(low_en), .high_en_o(high_en), .row_idx_o(row_idx),
    .col_idx_o(col_idx), .mute_o(mute), .run_o(run)
  );

  task automatic chk(string tag, logic el, logic eh, logic [1:0] er, logic [1:0] ec,
                     logic em, logic eru);
    checks++;
    if ({low_en, high_en, row_idx, col_idx, mute, run} !== {el, eh, er, ec, em, eru}) begin
      failures++;
      $display("FAIL %s: low=%b high=%b ridx=%0d cidx=%0d mute=%b run=%b exp %b %b %0d %0d %b %b",
               tag, low_en, high_en, row_idx, col_idx, mute, run, el, eh, er, ec, em, eru);
    end
  endtask

  // active-high masks in, active-low lines out; applied on a falling edge
  task automatic apply(logic [3:0] rows, logic [3:0] cols, logic ok, logic al);
    @(negedge clk);
    row_n = ~rows; col_n = ~cols; single_ok = ok; allow = al;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    #5; chk("R12 in reset", 0, 0, 0, 0, 0, 0);
    repeat (2) @(posedge clk);
    #2; chk("R12 held", 0, 0, 0, 0, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    settle(); chk("R8 idle after reset", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_latency();
    apply(4'b0001, 4'b0010, 1'b0, 1'b1);
    repeat (2) @(posedge clk); #2;
    chk("R10 not before third edge", 0, 0, 0, 0, 1'b0, 0);
    @(posedge clk); #2;
    exp_r = 2'd0; exp_c = 2'd1;
    chk("R10 at third edge", 1, 1, exp_r, exp_c, 1, 1);
  endtask

  task automatic t_valid_all();
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        apply(4'(1 << r), 4'(1 << c), 1'(c[0]), 1'b1);
        settle();
        exp_r = 2'(r); exp_c = 2'(c);
        chk("R1 R11 valid pair", 1, 1, exp_r, exp_c, 1, 1);
      end
  endtask

  task automatic t_single_high();
    apply(4'b0101, 4'b0100, 1'b1, 1'b1);
    settle(); exp_c = 2'd2;
    chk("R2 high group only", 0, 1, exp_r, exp_c, 1, 1);
  endtask

  task automatic t_single_low();
    apply(4'b0010, 4'b1001, 1'b1, 1'b1);
    settle(); exp_r = 2'd1;
    chk("R3 low group only", 1, 0, exp_r, exp_c, 1, 1);
  endtask

  task automatic t_multi_multi();
    apply(4'b0011, 4'b0110, 1'b1, 1'b1);
    settle(); chk("R4 multi rows multi cols", 0, 0, exp_r, exp_c, 1, 0);
  endtask

  task automatic t_inhibit();
    apply(4'b1100, 4'b0001, 1'b0, 1'b1);
    settle(); chk("R5 multi rows inhibited", 0, 0, exp_r, exp_c, 1, 0);
    apply(4'b1000, 4'b0011, 1'b0, 1'b1);
    settle(); chk("R5 multi cols inhibited", 0, 0, exp_r, exp_c, 1, 0);
  endtask

  task automatic t_col_only();
    apply(4'b0000, 4'b0100, 1'b1, 1'b1);
    settle(); chk("R9 column only no run", 0, 0, exp_r, exp_c, 1, 0);
    apply(4'b0100, 4'b0000, 1'b0, 1'b1);
    settle(); chk("R6 row only mutes", 0, 0, exp_r, exp_c, 1, 0);
  endtask

  task automatic t_disable();
    apply(4'b1000, 4'b1000, 1'b1, 1'b0);
    settle(); chk("R7 disabled valid key", 0, 0, exp_r, exp_c, 1, 0);
    apply(4'b1000, 4'b1000, 1'b1, 1'b1);
    settle(); exp_r = 2'd3; exp_c = 2'd3;
    chk("R7 re-enabled", 1, 1, exp_r, exp_c, 1, 1);
  endtask

  task automatic t_release();
    apply(4'b0000, 4'b0000, 1'b1, 1'b1);
    settle(); chk("R8 release", 0, 0, exp_r, exp_c, 0, 0);
  endtask

  initial begin : watchdog
    #2_000_000;
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_valid_all();
    t_single_high();
    t_single_low();
    t_multi_multi();
    t_inhibit();
    t_col_only();
    t_disable();
    t_release();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule